// File: doc/BRIEF.md
# Privilege-Based Virtual Address Segment Decoder

This block stands in front of a translation lookaside buffer. It classifies each 32-bit virtual address according to the privilege level the processor is running at, and gives one of three results. The first is a direct translation for the fixed kernel windows, with a physical address and an uncached marker. The second is a request that the TLB translate the address. The third is an address fault, typed as a load error, a store error or a fetch-alignment error.

The effective privilege comes from a 2-bit mode field and two status bits, the error level and the exception level. If either status bit is set, the level is kernel. The unused mode encoding is also treated as kernel.

Every request is accepted on the cycle its valid bit is high. The result appears on registered outputs one clock later. There is no back-pressure.

Top module: `vaddr_class_unit`

## Requirements
- R1: `rsp_valid` is `req_valid` delayed by exactly one clock. While reset is held, `rsp_valid` and every result output are zero.
- R2: When `req_err_lvl` or `req_exc_lvl` is 1, the request is decoded as kernel, whatever the value of `req_mode`.
- R3: Mode encodings are 0 = kernel, 1 = supervisor and 2 = user. Encoding 3 is decoded as kernel.
- R4: In kernel mode, addresses 0x80000000 through 0x9FFFFFFF produce `rsp_direct` with `rsp_paddr` = address − 0x80000000 and `rsp_uncached` = 0.
- R5: In kernel mode, addresses 0xA0000000 through 0xBFFFFFFF produce `rsp_direct` with `rsp_paddr` = address − 0xA0000000 and `rsp_uncached` = 1.
- R6: In supervisor mode, an address fault is raised unless address bits [31:29] are 3'b000 or 3'b110.
- R7: In user mode, an address fault is raised whenever address bit 31 is 1.
- R8: `rsp_fault_code` is 2'd1 for a load address fault and 2'd2 for a store address fault (`req_store` = 1). It is 2'd3 for a fetch-alignment fault, and 2'd0 whenever `rsp_fault` is 0.
- R9: When `req_fetch` is 1 and address bits [1:0] are not zero, the result is a fetch-alignment fault. This check takes priority over mode and window decoding.
- R10: Every other valid request produces `rsp_tlb_req`. In that case `rsp_paddr` is 0 and `rsp_uncached` is 0. For every valid response, `rsp_vaddr` carries the request address.
- R11: When `rsp_valid` is 1, exactly one of `rsp_direct`, `rsp_tlb_req` and `rsp_fault` is 1. When `rsp_valid` is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_mode | input | 2 | Privilege mode field (0 kernel, 1 supervisor, 2 user, 3 treated as kernel) |
| req_err_lvl | input | 1 | Error-level status bit; forces kernel |
| req_exc_lvl | input | 1 | Exception-level status bit; forces kernel |
| req_store | input | 1 | 1 = store access, 0 = load access |
| req_fetch | input | 1 | 1 = instruction fetch |
| rsp_valid | output | 1 | Result valid |
| rsp_direct | output | 1 | Unmapped window hit; `rsp_paddr` is valid |
| rsp_paddr | output | 32 | Physical address of a direct translation, else 0 |
| rsp_uncached | output | 1 | Direct translation is in the uncached window |
| rsp_tlb_req | output | 1 | Address must be translated by the TLB |
| rsp_vaddr | output | 32 | Virtual address of the request being answered |
| rsp_fault | output | 1 | Address fault |
| rsp_fault_code | output | 2 | 1 load, 2 store, 3 fetch alignment, 0 none |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency and the echoed address;
- that exactly one result class is asserted;
- the consistency of the fault code with the fault flag;
- the forced-kernel and bad-encoding decodes;
- the supervisor and user fault conditions and the priority of fetch alignment;
- the address arithmetic of both direct windows.

Other behaviour can only be shown by the bench's scenarios. This covers the exact boundary addresses at the window edges, the choice between load and store fault codes across mixed traffic, and back-to-back requests broken by idle cycles. The bench compares each of these against a model built from address ranges.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  // Effective privilege level after status overrides
  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_BAD    = 2'd3
  } priv_e;

  // Fault type reported on the response
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2,
    FLT_FETCH = 2'd3
  } fault_e;

  // Result class of one request
  typedef enum logic [1:0] {
    CLS_TLB    = 2'd0,
    CLS_DIRECT = 2'd1,
    CLS_FAULT  = 2'd2
  } class_e;

  // Status bits or the illegal encoding force kernel level
  function automatic priv_e resolve_priv(logic [1:0] field, logic err_lvl, logic exc_lvl);
    priv_e p;
    if (err_lvl || exc_lvl) begin
      p = PRIV_KERNEL;
    end else begin
      case (field)
        2'd1:    p = PRIV_SUPER;
        2'd2:    p = PRIV_USER;
        default: p = PRIV_KERNEL;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/vseg_mode_resolve.sv
module vseg_mode_resolve
  import vseg_pkg::*;
(
  input  logic [1:0] mode_field,
  input  logic       err_lvl,
  input  logic       exc_lvl,
  output priv_e      eff_priv
);

  always_comb begin
    eff_priv = resolve_priv(mode_field, err_lvl, exc_lvl);
  end

endmodule

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  priv_e             priv,
  input  logic              is_store,
  input  logic              is_fetch,
  output class_e            cls,
  output fault_e            fcode,
  output logic [ADDR_W-1:0] paddr,
  output logic              uncached
);

  localparam int TOP = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CACHED_BASE   = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] UNCACHED_BASE = {3'b101, {(ADDR_W-3){1'b0}}};

  // The top two bits select the whole unmapped kernel span
  function automatic logic in_direct_span(logic [ADDR_W-1:0] a);
    return a[TOP -: 2] == 2'b10;
  endfunction

  // Supervisor may only reach the lowest and the supervisor-mapped window
  function automatic logic super_reachable(logic [ADDR_W-1:0] a);
    return (a[TOP -: 3] == 3'b000) || (a[TOP -: 3] == 3'b110);
  endfunction

  // Direct translation subtracts the base of the window that was hit
  function automatic logic [ADDR_W-1:0] unmap(logic [ADDR_W-1:0] a);
    return a - (a[TOP-2] ? UNCACHED_BASE : CACHED_BASE);
  endfunction

  logic   misaligned_fetch;
  fault_e seg_fault;

  assign misaligned_fetch = is_fetch && (vaddr[1:0] != 2'b00);
  assign seg_fault        = is_store ? FLT_STORE : FLT_LOAD;

  always_comb begin
    cls      = CLS_TLB;
    fcode    = FLT_NONE;
    paddr    = '0;
    uncached = 1'b0;
    if (misaligned_fetch) begin
      cls   = CLS_FAULT;
      fcode = FLT_FETCH;
    end else begin
      case (priv)
        PRIV_SUPER: begin
          if (!super_reachable(vaddr)) begin
            cls   = CLS_FAULT;
            fcode = seg_fault;
          end
        end
        PRIV_USER: begin
          if (vaddr[TOP]) begin
            cls   = CLS_FAULT;
            fcode = seg_fault;
          end
        end
        default: begin
          if (in_direct_span(vaddr)) begin
            cls      = CLS_DIRECT;
            paddr    = unmap(vaddr);
            uncached = vaddr[TOP-2];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vseg_rsp_stage.sv
module vseg_rsp_stage
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  class_e            in_cls,
  input  fault_e            in_fcode,
  input  logic [ADDR_W-1:0] in_paddr,
  input  logic              in_uncached,
  input  logic [ADDR_W-1:0] in_vaddr,
  output logic              out_valid,
  output logic              out_direct,
  output logic              out_tlb,
  output logic              out_fault,
  output logic [1:0]        out_fcode,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_uncached,
  output logic [ADDR_W-1:0] out_vaddr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_direct   <= 1'b0;
      out_tlb      <= 1'b0;
      out_fault    <= 1'b0;
      out_fcode    <= 2'd0;
      out_paddr    <= '0;
      out_uncached <= 1'b0;
      out_vaddr    <= '0;
    end else begin
      out_valid    <= in_valid;
      out_direct   <= in_valid && (in_cls == CLS_DIRECT);
      out_tlb      <= in_valid && (in_cls == CLS_TLB);
      out_fault    <= in_valid && (in_cls == CLS_FAULT);
      out_fcode    <= in_valid ? in_fcode : FLT_NONE;
      out_paddr    <= in_valid ? in_paddr : '0;
      out_uncached <= in_valid && in_uncached;
      out_vaddr    <= in_valid ? in_vaddr : '0;
    end
  end

  // R11: one class per valid response, none when idle
  assert_one_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_direct, out_tlb, out_fault}) == 1);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_direct || out_tlb || out_fault));

  // R8: fault code is non-zero exactly when a fault is flagged
  assert_code_matches_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault == (out_fcode != 2'd0));

endmodule

// File: rtl/vaddr_class_unit.sv
module vaddr_class_unit
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_mode,
  input  logic              req_err_lvl,
  input  logic              req_exc_lvl,
  input  logic              req_store,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic              rsp_direct,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_uncached,
  output logic              rsp_tlb_req,
  output logic [ADDR_W-1:0] rsp_vaddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fault_code
);

  localparam int TOP = ADDR_W - 1;

  priv_e             eff_priv;
  class_e            cls;
  fault_e            fcode;
  logic [ADDR_W-1:0] direct_paddr;
  logic              direct_uncached;
  logic              fetch_misaligned;

  // Event wire for the checks below
  assign fetch_misaligned = req_fetch && (req_vaddr[1:0] != 2'b00);

  vseg_mode_resolve u_mode (
    .mode_field (req_mode),
    .err_lvl    (req_err_lvl),
    .exc_lvl    (req_exc_lvl),
    .eff_priv   (eff_priv)
  );

  vseg_classify #(.ADDR_W(ADDR_W)) u_classify (
    .vaddr    (req_vaddr),
    .priv     (eff_priv),
    .is_store (req_store),
    .is_fetch (req_fetch),
    .cls      (cls),
    .fcode    (fcode),
    .paddr    (direct_paddr),
    .uncached (direct_uncached)
  );

  vseg_rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (req_valid),
    .in_cls       (cls),
    .in_fcode     (fcode),
    .in_paddr     (direct_paddr),
    .in_uncached  (direct_uncached),
    .in_vaddr     (req_vaddr),
    .out_valid    (rsp_valid),
    .out_direct   (rsp_direct),
    .out_tlb      (rsp_tlb_req),
    .out_fault    (rsp_fault),
    .out_fcode    (rsp_fault_code),
    .out_paddr    (rsp_paddr),
    .out_uncached (rsp_uncached),
    .out_vaddr    (rsp_vaddr)
  );

  // R1: one-cycle response latency
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2: status bits force kernel, so the unmapped span is direct
  assert_status_forces_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_err_lvl || req_exc_lvl) && !fetch_misaligned
     && req_vaddr[TOP -: 2] == 2'b10) |=> rsp_direct);

  // R3: encoding 3 behaves as kernel
  assert_bad_mode_is_kernel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3 && !fetch_misaligned
     && req_vaddr[TOP -: 2] == 2'b10) |=> rsp_direct);

  // R4: cached window arithmetic
  assert_cached_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_direct && !rsp_uncached) |->
      (rsp_vaddr[TOP -: 3] == 3'b100 && rsp_paddr == {3'b000, rsp_vaddr[TOP-3:0]}));

  // R5: uncached window arithmetic
  assert_uncached_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_direct && rsp_uncached) |->
      (rsp_vaddr[TOP -: 3] == 3'b101 && rsp_paddr == {3'b000, rsp_vaddr[TOP-3:0]}));

  // R6: supervisor faults outside its two windows
  assert_super_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && eff_priv == PRIV_SUPER && !fetch_misaligned
     && req_vaddr[TOP -: 3] != 3'b000 && req_vaddr[TOP -: 3] != 3'b110) |=> rsp_fault);

  // R7: user faults on the upper half
  assert_user_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && eff_priv == PRIV_USER && !fetch_misaligned && req_vaddr[TOP])
      |=> rsp_fault);

  // R9: fetch alignment takes priority
  assert_fetch_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fetch_misaligned) |=> (rsp_fault && rsp_fault_code == 2'd3));

  // R10: TLB path carries no physical address; address echoed
  assert_tlb_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tlb_req |-> (rsp_paddr == '0 && !rsp_uncached));
  assert_vaddr_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_vaddr == $past(req_vaddr));

endmodule

// File: tb/test_vaddr_class_unit.sv
module test_vaddr_class_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_err_lvl = 1'b0;
  logic        req_exc_lvl = 1'b0;
  logic        req_store = 1'b0;
  logic        req_fetch = 1'b0;
  logic        rsp_valid, rsp_direct, rsp_uncached, rsp_tlb_req, rsp_fault;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic [1:0]  rsp_fault_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  vaddr_class_unit i_vaddr_class_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_err_lvl(req_err_lvl), .req_exc_lvl(req_exc_lvl),
    .req_store(req_store), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
    .rsp_direct(rsp_direct), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_tlb_req(rsp_tlb_req), .rsp_vaddr(rsp_vaddr), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code)
  );

  // Expected {direct, tlb, fault, code[1:0], uncached, paddr[31:0]} from address ranges
  function automatic logic [37:0] expect_rsp(logic [31:0] va, logic [1:0] mode,
                                             logic err, logic exc, logic st, logic fe);
    int lvl;
    logic [1:0] ac;
    lvl = (err || exc || mode == 2'd3) ? 0 : int'(mode);
    ac  = st ? 2'd2 : 2'd1;
    if (fe && (va % 4) != 0) return {3'b001, 2'd3, 1'b0, 32'd0};
    if (lvl == 0) begin
      if (va >= 32'h8000_0000 && va < 32'hA000_0000)
        return {3'b100, 2'd0, 1'b0, va - 32'h8000_0000};
      if (va >= 32'hA000_0000 && va < 32'hC000_0000)
        return {3'b100, 2'd0, 1'b1, va - 32'hA000_0000};
      return {3'b010, 2'd0, 1'b0, 32'd0};
    end
    if (lvl == 1) begin
      if (va < 32'h2000_0000 || (va >= 32'hC000_0000 && va < 32'hE000_0000))
        return {3'b010, 2'd0, 1'b0, 32'd0};
      return {3'b001, ac, 1'b0, 32'd0};
    end
    if (va < 32'h8000_0000) return {3'b010, 2'd0, 1'b0, 32'd0};
    return {3'b001, ac, 1'b0, 32'd0};
  endfunction

  function automatic string rule_of(logic [37:0] e, logic [31:0] va, logic [1:0] mode,
                                    logic err, logic exc);
    if (e[34:33] == 2'd3) return "R9";
    if (e[37]) return e[32] ? "R5" : "R4";
    if (e[35]) return (mode == 2'd1 && !err && !exc) ? "R6" : "R7";
    if (va[1:0] == 2'b00 && (err || exc)) return "R2";
    return "R10";
  endfunction

  // Called just after a falling edge; result checked at the next falling edge
  task automatic apply(string tag, logic [31:0] va, logic [1:0] mode,
                       logic err, logic exc, logic st, logic fe);
    logic [37:0] exp;
    logic [37:0] act;
    string t;
    req_valid = 1'b1; req_vaddr = va; req_mode = mode;
    req_err_lvl = err; req_exc_lvl = exc; req_store = st; req_fetch = fe;
    exp = expect_rsp(va, mode, err, exc, st, fe);
    t = (tag == "") ? rule_of(exp, va, mode, err, exc) : tag;
    @(negedge clk);
    act = {rsp_direct, rsp_tlb_req, rsp_fault, rsp_fault_code, rsp_uncached, rsp_paddr};
    checks++;
    if (rsp_valid !== 1'b1 || act !== exp || rsp_vaddr !== va) begin
      fails++;
      $display("FAIL %s va=%h mode=%0d: actual valid=%b res=%h vaddr=%h expected valid=1 res=%h vaddr=%h",
               t, va, mode, rsp_valid, act, rsp_vaddr, exp, va);
    end
  endtask

  task automatic idle(string tag);
    req_valid = 1'b0;
    req_vaddr = 32'hFFFF_FFFF;
    @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_direct, rsp_tlb_req, rsp_fault} !== 4'b0000) begin
      fails++;
      $display("FAIL %s idle: actual valid/direct/tlb/fault=%b expected 0000",
               tag, {rsp_valid, rsp_direct, rsp_tlb_req, rsp_fault});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if ({rsp_valid, rsp_direct, rsp_tlb_req, rsp_fault, rsp_uncached} !== 5'b0 ||
        rsp_paddr !== 32'd0 || rsp_fault_code !== 2'd0) begin
      fails++;
      $display("FAIL R1 reset: actual valid=%b paddr=%h expected valid=0 paddr=0",
               rsp_valid, rsp_paddr);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Kernel window boundaries: R4, R5, R10
    apply("R10", 32'h7FFF_FFFF, 2'd0, 0, 0, 0, 0);
    apply("R4",  32'h8000_0000, 2'd0, 0, 0, 0, 0);
    apply("R4",  32'h9FFF_FFFF, 2'd0, 0, 0, 1, 0);
    apply("R5",  32'hA000_0000, 2'd0, 0, 0, 0, 0);
    apply("R5",  32'hBFFF_FFFC, 2'd0, 0, 0, 0, 1);
    apply("R10", 32'hC000_0000, 2'd0, 0, 0, 0, 0);
    idle("R1");
    // Supervisor windows: R6, R8
    apply("R6",  32'h1FFF_FFFF, 2'd1, 0, 0, 0, 0);
    apply("R6",  32'h2000_0000, 2'd1, 0, 0, 0, 0);
    apply("R8",  32'hE000_0000, 2'd1, 0, 0, 1, 0);
    apply("R6",  32'hDFFF_FFFF, 2'd1, 0, 0, 0, 0);
    apply("R6",  32'h8000_0000, 2'd1, 0, 0, 1, 0);
    // User: R7, R8
    apply("R7",  32'h7FFF_FFFC, 2'd2, 0, 0, 0, 1);
    apply("R7",  32'h8000_0000, 2'd2, 0, 0, 1, 0);
    apply("R8",  32'hA000_0000, 2'd2, 0, 0, 0, 0);
    // Forced kernel and bad encoding: R2, R3
    apply("R2",  32'hA000_0004, 2'd2, 0, 1, 0, 0);
    apply("R2",  32'h8123_4567, 2'd1, 1, 0, 1, 0);
    apply("R3",  32'h8000_0010, 2'd3, 0, 0, 0, 0);
    apply("R3",  32'hF000_0000, 2'd3, 0, 0, 1, 0);
    // Fetch alignment priority: R9
    apply("R9",  32'h8000_0001, 2'd0, 0, 0, 0, 1);
    apply("R9",  32'hF000_0002, 2'd2, 0, 0, 1, 1);
    apply("R9",  32'h0000_0003, 2'd1, 0, 1, 0, 1);
    apply("R9",  32'h8000_0001, 2'd2, 0, 0, 0, 0);
    idle("R11");

    // Constrained random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] va;
      logic [1:0]  md;
      logic        fe;
      va = $urandom;
      if (($urandom % 4) != 0) va[1:0] = 2'b00;
      md = 2'($urandom % 4);
      fe = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) idle("R11");
      apply("", va, md, ($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2, fe);
    end
    idle("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule